// File: doc/BRIEF.md
# Transmit Endpoint Event Aggregator

This block gathers the transmit outcome of four transmit endpoints into one read-only 8-bit event register. Each endpoint owns two sticky flags. The first records that an IN transaction on that endpoint has completed. The second records that the endpoint's transmit FIFO has run dry during a transfer (an underrun). The endpoint's transmit logic signals each of these events with a one-cycle pulse.

Flags are not cleared by reading the aggregate register. A flag pair clears only when software reads that endpoint's own transmit status register, and the block receives that read as a one-cycle strobe per endpoint. Endpoint 0 forwards a packet only after storing all of it, so it cannot underrun, and its underrun flag is tied to zero. A summary output feeds the main interrupt register and is high whenever any flag is set. Writes to the register address have no effect.

Each endpoint is a four-state machine over its flag pair:

- `EP_QUIET`: no flag set.
- `EP_DONE`: the done flag only.
- `EP_URUN`: the underrun flag only.
- `EP_BOTH`: both flags.

Every state can move to every other state. The kept flags are the flags of the current state, or none when a status read is present. The next state is the kept flags OR the flags of the incoming pulses, which gives these transitions:

- A done pulse moves QUIET to DONE and URUN to BOTH.
- An underrun pulse moves QUIET to URUN and DONE to BOTH.
- A status read alone moves any state to QUIET.
- A status read together with pulses moves any state to the state that holds exactly the pulsed flags.
- With no pulse and no read, the state holds.

Top module: `tx_event_agg`

## Requirements
- R1: After reset, `tx_event` is 8'h00 and `tx_any` is 0.
- R2: A pulse on `in_done[k]` sets bit k of `tx_event` (the done flags sit in bits 3..0, with endpoint k at bit k) from the clock edge that samples the pulse.
- R3: For endpoints 1 to 3, a pulse on `in_urun[k]` sets bit 4+k of `tx_event` (the underrun flags sit in bits 7..4, with endpoint k at bit 4+k) from the clock edge that samples the pulse.
- R4: Bit 4, the underrun flag of endpoint 0, always reads 0, and pulses on `in_urun[0]` are ignored.
- R5: A strobe on `stat_rd[k]` clears bits k and 4+k at the sampling edge and leaves the other endpoints' bits unchanged.
- R6: When a done or underrun pulse for endpoint k arrives in the same cycle as `stat_rd[k]`, the pulsed flag is set after the edge and the other flag of that endpoint is cleared.
- R7: `tx_any` is 1 exactly when at least one bit of `tx_event` is 1.
- R8: A write strobe `reg_wr_en` never changes `tx_event`.
- R9: A set flag stays set until its endpoint's status read. Repeated pulses leave it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_done | input | 4 | Per-endpoint IN-transaction-complete pulses |
| in_urun | input | 4 | Per-endpoint transmit FIFO underrun pulses |
| stat_rd | input | 4 | Per-endpoint status-register read strobes |
| reg_wr_en | input | 1 | Write strobe to the event register address (ignored) |
| tx_event | output | 8 | Event register: underrun flags in 7..4, done flags in 3..0 |
| tx_any | output | 1 | High when any event flag is set |

## Verification
Every set and clear becomes visible immediately after the one clock edge that samples the pulse or strobe. `tx_event` and `tx_any` are decoded combinationally from the state registers, so there is no further delay. The bench drives its inputs on the falling edge. A behavioural model updates on the rising edge from those same inputs, and the outputs are compared with the model one time unit after each rising edge, which is the cycle in which the result is due. Directed checks sample on the next falling edge and cover the cases where a pulse and a status read land in the same cycle, as well as the ignored endpoint 0 underrun and the ignored write.

// File: rtl/tx_evt_pkg.sv
package tx_evt_pkg;

    // Flag-pair states of one transmit endpoint
    typedef enum logic [1:0] {
        EP_QUIET = 2'b00,
        EP_DONE  = 2'b01,
        EP_URUN  = 2'b10,
        EP_BOTH  = 2'b11
    } ep_state_e;

endpackage

// File: rtl/tx_ep_flags.sv
module tx_ep_flags
    import tx_evt_pkg::*;
#(
    parameter bit HAS_URUN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic done_i,
    input  logic urun_i,
    input  logic clr_i,
    output logic done_o,
    output logic urun_o
);

    localparam logic URUN_EN = HAS_URUN;

    ep_state_e state_q;
    ep_state_e state_d;
    logic      keep_done;
    logic      keep_urun;
    logic      urun_ev;

    assign urun_ev = urun_i & URUN_EN;

    // Which flags survive this cycle (a status read drops both)
    always_comb begin
        keep_done = 1'b0;
        keep_urun = 1'b0;
        unique case (state_q)
            EP_QUIET: begin
                keep_done = 1'b0;
                keep_urun = 1'b0;
            end
            EP_DONE: begin
                keep_done = !clr_i;
                keep_urun = 1'b0;
            end
            EP_URUN: begin
                keep_done = 1'b0;
                keep_urun = !clr_i;
            end
            EP_BOTH: begin
                keep_done = !clr_i;
                keep_urun = !clr_i;
            end
            default: begin
                keep_done = 1'b0;
                keep_urun = 1'b0;
            end
        endcase
    end

    // Next state: kept flags plus new events (new events win over a read)
    always_comb begin
        unique case ({keep_urun | urun_ev, keep_done | done_i})
            2'b00:   state_d = EP_QUIET;
            2'b01:   state_d = EP_DONE;
            2'b10:   state_d = EP_URUN;
            2'b11:   state_d = EP_BOTH;
            default: state_d = EP_QUIET;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EP_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            EP_QUIET: begin
                done_o = 1'b0;
                urun_o = 1'b0;
            end
            EP_DONE: begin
                done_o = 1'b1;
                urun_o = 1'b0;
            end
            EP_URUN: begin
                done_o = 1'b0;
                urun_o = 1'b1;
            end
            EP_BOTH: begin
                done_o = 1'b1;
                urun_o = 1'b1;
            end
            default: begin
                done_o = 1'b0;
                urun_o = 1'b0;
            end
        endcase
    end

    AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n) done_i |=> done_o); // R2
    AST_URUN_SETS: assert property (@(posedge clk) disable iff (!rst_n) (URUN_EN && urun_i) |=> urun_o); // R3
    AST_NO_EP0_URUN: assert property (@(posedge clk) disable iff (!rst_n) !URUN_EN |-> !urun_o); // R4
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (clr_i && !done_i && !urun_i) |=> (!done_o && !urun_o)); // R5
    AST_READ_PULSE_WINS: assert property (@(posedge clk) disable iff (!rst_n) (clr_i && done_i && !urun_i) |=> (done_o && !urun_o)); // R6
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (!clr_i && done_o) |=> done_o); // R9
    AST_URUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (!clr_i && urun_o) |=> urun_o); // R9

endmodule

// File: rtl/tx_evt_pack.sv
module tx_evt_pack #(
    parameter int unsigned EP_COUNT = 4,
    localparam int unsigned EVT_W = 2 * EP_COUNT
) (
    input  logic [EP_COUNT-1:0] done_vec,
    input  logic [EP_COUNT-1:0] urun_vec,
    output logic [EVT_W-1:0]    evt_reg,
    output logic                any_o
);

    // Done flags in the low half, underrun flags in the high half
    for (genvar k = 0; k < EP_COUNT; k++) begin : g_slot
        assign evt_reg[k]            = done_vec[k];
        assign evt_reg[EP_COUNT + k] = urun_vec[k];
    end

    assign any_o = (evt_reg != '0);

endmodule

// File: rtl/tx_event_agg.sv
module tx_event_agg #(
    parameter int unsigned EP_COUNT = 4,
    localparam int unsigned EVT_W = 2 * EP_COUNT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [EP_COUNT-1:0] in_done,
    input  logic [EP_COUNT-1:0] in_urun,
    input  logic [EP_COUNT-1:0] stat_rd,
    input  logic                reg_wr_en,
    output logic [EVT_W-1:0]    tx_event,
    output logic                tx_any
);

    logic [EP_COUNT-1:0] done_vec;
    logic [EP_COUNT-1:0] urun_vec;

    // Endpoint 0 is store-and-forward: its underrun path is left out
    for (genvar k = 0; k < EP_COUNT; k++) begin : g_ep
        tx_ep_flags #(
            .HAS_URUN(k != 0)
        ) u_flags (
            .clk    (clk),
            .rst_n  (rst_n),
            .done_i (in_done[k]),
            .urun_i (in_urun[k]),
            .clr_i  (stat_rd[k]),
            .done_o (done_vec[k]),
            .urun_o (urun_vec[k])
        );
    end

    tx_evt_pack #(
        .EP_COUNT(EP_COUNT)
    ) u_pack (
        .done_vec (done_vec),
        .urun_vec (urun_vec),
        .evt_reg  (tx_event),
        .any_o    (tx_any)
    );

    AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (reg_wr_en && in_done == '0 && in_urun == '0 && stat_rd == '0) |=> $stable(tx_event)); // R8
    AST_ANY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_any) |-> $past(in_done != '0 || in_urun[EP_COUNT-1:1] != '0)); // R7

endmodule

// File: tb/tx_event_agg_test.sv
module tx_event_agg_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] in_done = '0;
    logic [3:0] in_urun = '0;
    logic [3:0] stat_rd = '0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] tx_event;
    logic       tx_any;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int model_done [4];
    int model_urun [4];

    always #5 clk = ~clk;

    tx_event_agg uut (
        .clk(clk), .rst_n(rst_n), .in_done(in_done), .in_urun(in_urun),
        .stat_rd(stat_rd), .reg_wr_en(reg_wr_en),
        .tx_event(tx_event), .tx_any(tx_any)
    );

    function automatic logic [7:0] model_reg();
        logic [7:0] v = '0;
        for (int k = 0; k < 4; k++) begin
            v[k]   = (model_done[k] != 0);
            v[4+k] = (model_urun[k] != 0);
        end
        return v;
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // Behavioural model, compared one time unit after every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 4; k++) begin
                model_done[k] = 0;
                model_urun[k] = 0;
            end
        end else begin
            for (int k = 0; k < 4; k++) begin
                if (stat_rd[k]) begin
                    model_done[k] = 0;
                    model_urun[k] = 0;
                end
                if (in_done[k]) model_done[k] = 1;
                if (in_urun[k] && k != 0) model_urun[k] = 1;
            end
        end
        #1;
        if (rst_n) begin
            chk("R2/R3/R4/R5/R6/R9 per-cycle tx_event", tx_event, model_reg());
            chk("R7 per-cycle tx_any", {7'd0, tx_any}, {7'd0, (model_reg() != 0)});
        end
    end

    task automatic step(input logic [3:0] d, input logic [3:0] u, input logic [3:0] r, input logic w);
        in_done = d; in_urun = u; stat_rd = r; reg_wr_en = w;
        @(negedge clk);
        in_done = '0; in_urun = '0; stat_rd = '0; reg_wr_en = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr = 8'hA5;
        repeat (3) @(negedge clk);
        chk("R1 reset tx_event", tx_event, 8'h00);
        chk("R1 reset tx_any", {7'd0, tx_any}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset release", tx_event, 8'h00);

        step(4'b0001, 4'b0000, 4'b0000, 1'b0);
        chk("R2 done ep0 sets bit0", tx_event, 8'h01);
        chk("R7 any high", {7'd0, tx_any}, 8'h01);
        step(4'b0000, 4'b0001, 4'b0000, 1'b0);
        chk("R4 ep0 underrun ignored", tx_event, 8'h01);
        step(4'b0000, 4'b1110, 4'b0000, 1'b0);
        chk("R3 underrun ep1-3", tx_event, 8'hE1);
        step(4'b1110, 4'b0000, 4'b0000, 1'b0);
        chk("R2 done ep1-3", tx_event, 8'hEF);
        step(4'b0000, 4'b0000, 4'b0010, 1'b0);
        chk("R5 read ep1 clears bits 1,5", tx_event, 8'hCD);
        step(4'b0000, 4'b0000, 4'b0000, 1'b1);
        chk("R8 write ignored", tx_event, 8'hCD);
        repeat (5) step(4'b0000, 4'b0000, 4'b0000, 1'b0);
        chk("R9 flags sticky while idle", tx_event, 8'hCD);
        step(4'b0001, 4'b0000, 4'b0000, 1'b0);
        chk("R9 repeated pulse", tx_event, 8'hCD);
        step(4'b0100, 4'b0000, 4'b0100, 1'b0);
        chk("R6 done with read ep2", tx_event, 8'h8D);
        step(4'b0000, 4'b1000, 4'b1000, 1'b0);
        chk("R6 underrun with read ep3", tx_event, 8'h85);
        step(4'b0000, 4'b0000, 4'b1111, 1'b0);
        chk("R5 read all clears", tx_event, 8'h00);
        chk("R7 any low", {7'd0, tx_any}, 8'h00);

        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(lfsr[3:0] & {4{lfsr[7]}}, lfsr[7:4] & {4{lfsr[2]}},
                 lfsr[5:2] & {4{lfsr[0] & lfsr[6]}}, lfsr[1]);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule